// File: doc/BRIEF.md
# Endpoint Descriptor List Walker

This block is a bus-master engine that follows a singly linked chain of 16-byte endpoint descriptors in memory. Software supplies the address of the first descriptor and pulses `start`. The engine then fetches each descriptor as four 32-bit words through a one-outstanding request/response read port and decodes it. For every descriptor it either issues a transfer request to a downstream transfer unit or moves on to the next one. It stops when the masked next-descriptor pointer is zero.

A descriptor is passed over without any queue check when its skip flag or its halted flag is set. Otherwise the head and tail queue pointers are compared, and if they differ the TD at the head is scheduled. Pointers are masked to 16-byte granularity. Isochronous descriptors must carry 32-byte aligned queue pointers. A read error, a misaligned isochronous pointer or an overlong (looping) chain ends the walk and leaves a sticky error flag.

Top module: `ed_list_walker`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `xr_valid` and all three error flags are low.
- R2: A walk reads each descriptor at base+0, +4, +8, +12 in that order. Word 0 is control, word 1 is the tail pointer, word 2 is the head pointer and word 3 is the next pointer. The base is the pointer with bits [3:0] cleared. Only one read is outstanding at a time.
- R3: The next address is word 3 with bits [3:0] cleared. When that value is zero the walk ends with a one-cycle `done` pulse. A start with a list head that is zero after masking gives `done` and issues no read.
- R4: A descriptor with skip (control bit 14) or halted (word 2 bit 0) set produces no transfer request and no alignment check, and the walk continues to its successor.
- R5: For a descriptor that is not skipped or halted, head and tail are compared on bits [31:4]. If they are equal, no request is made and the walk continues.
- R6: If head and tail differ, one request is made. It carries function address (control [6:0]), endpoint number ([10:7]), low-speed flag ([13]), max packet size ([26:16]), isochronous flag ([15]) and the head address with bits [3:0] cleared.
- R7: The direction code [12:11] resolves as 01 to OUT (01) and 10 to IN (10). Both 00 and 11 resolve to "from TD" (00). `xr_early_in` is high exactly when the resolved direction is IN.
- R8: `xr_valid` stays high with a stable payload until `xr_ready`. No memory read is issued while a request is pending.
- R9: For a descriptor that is isochronous, not skipped and not halted, bit 4 set in the head or the tail sets `err_align` and ends the walk without a request.
- R10: A read response with `mem_rerr` set sets `err_read` and ends the walk.
- R11: After MAX_VISITS descriptors are evaluated, a non-zero next pointer sets `err_loop` and ends the walk.
- R12: `start` is ignored while `busy` is high. An accepted start clears the three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| list_head | input | 32 | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| err_read | output | 1 | Sticky: read response error |
| err_align | output | 1 | Sticky: isochronous pointer misaligned |
| err_loop | output | 1 | Sticky: visit limit reached |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the word read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| xr_valid | output | 1 | Transfer request valid |
| xr_ready | input | 1 | Transfer request accepted |
| xr_func_addr | output | 7 | Function address |
| xr_ep_num | output | 4 | Endpoint number |
| xr_low_speed | output | 1 | Low-speed endpoint |
| xr_max_pkt | output | 11 | Maximum packet size |
| xr_dir | output | 2 | Resolved direction code |
| xr_iso | output | 1 | Isochronous TD format |
| xr_early_in | output | 1 | IN token may be issued before the TD fetch |
| xr_td_addr | output | 32 | Address of the head TD |

## Verification
The bench builds the walker with MAX_VISITS set to 8, so a descriptor that links to itself runs into the visit limit after eight requests instead of 256. Bench memory holds sixteen descriptor slots, which is enough for chains that mix skip, halted, empty, isochronous and every direction code. The bench runs walks with zero-latency and two-cycle read responses and with a stalling ready pattern, which exercises the hold rule and the single-outstanding read rule.

// File: rtl/ed_walk_pkg.sv
package ed_walk_pkg;

    localparam int WORD_W   = 32;
    localparam int ED_WORDS = 4;
    localparam int FA_W     = 7;
    localparam int EP_W     = 4;
    localparam int MPS_W    = 11;
    localparam int DIR_W    = 2;
    localparam int PTR_LSB  = 4;

    // control word field positions
    localparam int FA_LO     = 0;
    localparam int EP_LO     = FA_LO + FA_W;
    localparam int DIR_LO    = EP_LO + EP_W;
    localparam int SPD_BIT   = DIR_LO + DIR_W;
    localparam int SKIP_BIT  = SPD_BIT + 1;
    localparam int ISO_BIT   = SKIP_BIT + 1;
    localparam int MPS_LO    = ISO_BIT + 1;
    localparam int CTRL_USED = MPS_LO + MPS_W;

    localparam int HALT_BIT      = 0;
    localparam int ISO_ALIGN_BIT = 4;

    // word order inside one descriptor
    localparam int W_CTRL = 0;
    localparam int W_TAIL = 1;
    localparam int W_HEAD = 2;
    localparam int W_NEXT = 3;

    typedef enum logic [DIR_W-1:0] {
        XDIR_TD  = 2'b00,
        XDIR_OUT = 2'b01,
        XDIR_IN  = 2'b10
    } xdir_e;

    typedef logic [ED_WORDS-1:0][WORD_W-1:0] ed_words_t;

    typedef struct packed {
        logic [FA_W-1:0]   fa;
        logic [EP_W-1:0]   ep;
        logic              low_speed;
        logic [MPS_W-1:0]  mps;
        xdir_e             dir;
        logic              iso;
        logic              early_in;
        logic [WORD_W-1:0] td_addr;
    } xfer_req_t;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FETCH,
        WK_EVAL,
        WK_ISSUE,
        WK_NEXT
    } walk_state_e;

    function automatic logic [WORD_W-1:0] ptr_base(input logic [WORD_W-1:0] p);
        return {p[WORD_W-1:PTR_LSB], {PTR_LSB{1'b0}}};
    endfunction

    function automatic xdir_e resolve_dir(input logic [DIR_W-1:0] code);
        case (code)
            2'b01:   return XDIR_OUT;
            2'b10:   return XDIR_IN;
            default: return XDIR_TD;
        endcase
    endfunction

endpackage

// File: rtl/ed_word_fetch.sv
module ed_word_fetch
    import ed_walk_pkg::*;
#(
    parameter int NWORDS = ED_WORDS,
    parameter int AW     = WORD_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         go,
    input  logic [AW-1:0]                base,
    input  logic                         mem_rvalid,
    input  logic [WORD_W-1:0]            mem_rdata,
    input  logic                         mem_rerr,
    output logic                         mem_req,
    output logic [AW-1:0]                mem_addr,
    output logic                         fin,
    output logic                         fail,
    output logic [NWORDS-1:0][WORD_W-1:0] words
);

    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_e;

    fetch_state_e       st;
    logic [AW-1:0]      base_q;
    logic [IDX_W-1:0]   idx;
    logic               take;

    assign take     = (st == F_WAIT) && mem_rvalid && !mem_rerr;
    assign mem_req  = (st == F_REQ);
    assign mem_addr = base_q + AW'({idx, 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_IDLE;
            base_q <= '0;
            idx    <= '0;
            fin    <= 1'b0;
            fail   <= 1'b0;
        end else begin
            fin  <= 1'b0;
            fail <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (go) begin
                        base_q <= base;
                        idx    <= '0;
                        st     <= F_REQ;
                    end
                end
                F_REQ: st <= F_WAIT;
                F_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_rerr) begin
                            fail <= 1'b1;
                            st   <= F_IDLE;
                        end else if (idx == LAST_IDX) begin
                            fin <= 1'b1;
                            st  <= F_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= F_REQ;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (take && idx == IDX_W'(g))
                words[g] <= mem_rdata;
        end
    end

endmodule

// File: rtl/ed_decode.sv
module ed_decode
    import ed_walk_pkg::*;
(
    input  ed_words_t         words,
    output logic              pass_over,
    output logic              align_bad,
    output logic              has_work,
    output logic [WORD_W-1:0] next_ed,
    output logic              list_end,
    output xfer_req_t         req
);

    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] tail_p;
    logic [WORD_W-1:0] head_p;
    logic              iso;
    logic              unused_bits;

    assign ctrl   = words[W_CTRL];
    assign tail_p = ptr_base(words[W_TAIL]);
    assign head_p = ptr_base(words[W_HEAD]);
    assign iso    = ctrl[ISO_BIT];

    assign pass_over = ctrl[SKIP_BIT] | words[W_HEAD][HALT_BIT];
    assign align_bad = iso & (words[W_TAIL][ISO_ALIGN_BIT] | words[W_HEAD][ISO_ALIGN_BIT]);
    assign has_work  = (head_p != tail_p);
    assign next_ed   = ptr_base(words[W_NEXT]);
    assign list_end  = (next_ed == '0);

    always_comb begin
        req           = '0;
        req.fa        = ctrl[FA_LO +: FA_W];
        req.ep        = ctrl[EP_LO +: EP_W];
        req.low_speed = ctrl[SPD_BIT];
        req.mps       = ctrl[MPS_LO +: MPS_W];
        req.dir       = resolve_dir(ctrl[DIR_LO +: DIR_W]);
        req.iso       = iso;
        req.early_in  = (req.dir == XDIR_IN);
        req.td_addr   = head_p;
    end

    assign unused_bits = ^{ctrl[WORD_W-1:CTRL_USED]};

endmodule

// File: rtl/ed_visit_guard.sv
module ed_visit_guard #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign at_limit = (cnt >= CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && !at_limit)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ed_list_walker.sv
module ed_list_walker
    import ed_walk_pkg::*;
#(
    parameter int MAX_VISITS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] list_head,
    output logic              busy,
    output logic              done,
    output logic              err_read,
    output logic              err_align,
    output logic              err_loop,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              xr_valid,
    input  logic              xr_ready,
    output logic [FA_W-1:0]   xr_func_addr,
    output logic [EP_W-1:0]   xr_ep_num,
    output logic              xr_low_speed,
    output logic [MPS_W-1:0]  xr_max_pkt,
    output logic [DIR_W-1:0]  xr_dir,
    output logic              xr_iso,
    output logic              xr_early_in,
    output logic [WORD_W-1:0] xr_td_addr
);

    walk_state_e       state;
    ed_words_t         words;
    logic              fetch_go;
    logic              fetch_fin;
    logic              fetch_fail;
    logic [WORD_W-1:0] fetch_base;
    logic [WORD_W-1:0] head_base;
    logic              accept_start;
    logic              pass_over;
    logic              align_bad;
    logic              has_work;
    logic [WORD_W-1:0] next_ed;
    logic              list_end;
    logic              at_limit;
    xfer_req_t         req_d;
    xfer_req_t         req_q;

    assign head_base    = ptr_base(list_head);
    assign accept_start = (state == WK_IDLE) && start;
    assign fetch_base   = (state == WK_IDLE) ? head_base : next_ed;
    assign fetch_go     = (accept_start && head_base != '0) ||
                          (state == WK_NEXT && !list_end && !at_limit);

    ed_word_fetch #(
        .NWORDS (ED_WORDS),
        .AW     (WORD_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (fetch_go),
        .base       (fetch_base),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fin        (fetch_fin),
        .fail       (fetch_fail),
        .words      (words)
    );

    ed_decode u_decode (
        .words     (words),
        .pass_over (pass_over),
        .align_bad (align_bad),
        .has_work  (has_work),
        .next_ed   (next_ed),
        .list_end  (list_end),
        .req       (req_d)
    );

    ed_visit_guard #(
        .LIMIT (MAX_VISITS)
    ) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept_start),
        .inc      (fetch_fin),
        .at_limit (at_limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= WK_IDLE;
            done      <= 1'b0;
            err_read  <= 1'b0;
            err_align <= 1'b0;
            err_loop  <= 1'b0;
            xr_valid  <= 1'b0;
            req_q     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WK_IDLE: begin
                    if (start) begin
                        err_read  <= 1'b0;
                        err_align <= 1'b0;
                        err_loop  <= 1'b0;
                        if (head_base == '0)
                            done <= 1'b1;
                        else
                            state <= WK_FETCH;
                    end
                end
                WK_FETCH: begin
                    if (fetch_fail) begin
                        err_read <= 1'b1;
                        done     <= 1'b1;
                        state    <= WK_IDLE;
                    end else if (fetch_fin) begin
                        state <= WK_EVAL;
                    end
                end
                WK_EVAL: begin
                    if (pass_over) begin
                        state <= WK_NEXT;
                    end else if (align_bad) begin
                        err_align <= 1'b1;
                        done      <= 1'b1;
                        state     <= WK_IDLE;
                    end else if (has_work) begin
                        req_q    <= req_d;
                        xr_valid <= 1'b1;
                        state    <= WK_ISSUE;
                    end else begin
                        state <= WK_NEXT;
                    end
                end
                WK_ISSUE: begin
                    if (xr_ready) begin
                        xr_valid <= 1'b0;
                        state    <= WK_NEXT;
                    end
                end
                WK_NEXT: begin
                    if (list_end) begin
                        done  <= 1'b1;
                        state <= WK_IDLE;
                    end else if (at_limit) begin
                        err_loop <= 1'b1;
                        done     <= 1'b1;
                        state    <= WK_IDLE;
                    end else begin
                        state <= WK_FETCH;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    assign busy         = (state != WK_IDLE);
    assign xr_func_addr = req_q.fa;
    assign xr_ep_num    = req_q.ep;
    assign xr_low_speed = req_q.low_speed;
    assign xr_max_pkt   = req_q.mps;
    assign xr_dir       = req_q.dir;
    assign xr_iso       = req_q.iso;
    assign xr_early_in  = req_q.early_in;
    assign xr_td_addr   = req_q.td_addr;

endmodule

// File: rtl/ed_walker_chk.sv
module ed_walker_chk
    import ed_walk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              err_read,
    input logic              err_align,
    input logic              err_loop,
    input logic              mem_req,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              xr_valid,
    input logic              xr_ready,
    input logic [FA_W-1:0]   xr_func_addr,
    input logic [EP_W-1:0]   xr_ep_num,
    input logic [MPS_W-1:0]  xr_max_pkt,
    input logic [DIR_W-1:0]  xr_dir,
    input logic              xr_early_in,
    input logic [WORD_W-1:0] xr_td_addr
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (mem_req)
            pend <= 1'b1;
        else if (mem_rvalid)
            pend <= 1'b0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !xr_valid));

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        pend |-> !mem_req);

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r6_td_aligned: assert property (@(posedge clk) disable iff (rst)
        xr_valid |-> (xr_td_addr[3:0] == 4'h0));

    a_r7_dir_code: assert property (@(posedge clk) disable iff (rst)
        xr_valid |-> (xr_dir != 2'b11));

    a_r7_early_in: assert property (@(posedge clk) disable iff (rst)
        xr_valid |-> (xr_early_in == (xr_dir == 2'b10)));

    a_r8_hold_payload: assert property (@(posedge clk) disable iff (rst)
        (xr_valid && !xr_ready) |=> (xr_valid && $stable(xr_td_addr) && $stable(xr_func_addr)
                                     && $stable(xr_ep_num) && $stable(xr_max_pkt) && $stable(xr_dir)));

    a_r8_no_read_while_valid: assert property (@(posedge clk) disable iff (rst)
        xr_valid |-> !mem_req);

    a_r12_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (!start && (err_read || err_align || err_loop)) |=>
            ($stable(err_read) && $stable(err_align) && $stable(err_loop)));

endmodule

bind ed_list_walker ed_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .err_read     (err_read),
    .err_align    (err_align),
    .err_loop     (err_loop),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .xr_valid     (xr_valid),
    .xr_ready     (xr_ready),
    .xr_func_addr (xr_func_addr),
    .xr_ep_num    (xr_ep_num),
    .xr_max_pkt   (xr_max_pkt),
    .xr_dir       (xr_dir),
    .xr_early_in  (xr_early_in),
    .xr_td_addr   (xr_td_addr)
);

// File: tb/sim_ed_list_walker.sv
module sim_ed_list_walker;

    localparam int LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] list_head;
    logic        busy, done, err_read, err_align, err_loop;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mem_rerr;
    logic        xr_valid;
    logic        xr_ready;
    logic [6:0]  xr_func_addr;
    logic [3:0]  xr_ep_num;
    logic        xr_low_speed;
    logic [10:0] xr_max_pkt;
    logic [1:0]  xr_dir;
    logic        xr_iso;
    logic        xr_early_in;
    logic [31:0] xr_td_addr;

    always #2 clk = ~clk;

    ed_list_walker #(.MAX_VISITS(LIMIT)) u0 (
        .clk(clk), .rst(rst), .start(start), .list_head(list_head),
        .busy(busy), .done(done), .err_read(err_read), .err_align(err_align),
        .err_loop(err_loop), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .xr_valid(xr_valid), .xr_ready(xr_ready), .xr_func_addr(xr_func_addr),
        .xr_ep_num(xr_ep_num), .xr_low_speed(xr_low_speed), .xr_max_pkt(xr_max_pkt),
        .xr_dir(xr_dir), .xr_iso(xr_iso), .xr_early_in(xr_early_in),
        .xr_td_addr(xr_td_addr)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] mem [0:63];
    int          lat_cfg = 0;
    bit          err_on = 1'b0;
    logic [31:0] err_addr = '0;
    bit          rdy_mode = 1'b0;
    int          rcnt = 0;

    logic [31:0] exp_addr[$];
    logic [58:0] exp_xr[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory responder: one request, fixed latency
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    int          wait_c = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            pend     <= 1'b0;
            mem_rerr <= 1'b0;
            mem_rdata <= '0;
        end else if (pend) begin
            if (wait_c == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr[7:2]];
                mem_rerr   <= err_on && (paddr == err_addr);
                pend       <= 1'b0;
            end else begin
                wait_c <= wait_c - 1;
            end
        end else if (mem_req) begin
            pend   <= 1'b1;
            paddr  <= mem_addr;
            wait_c <= lat_cfg;
        end
    end

    always @(posedge clk) begin
        rcnt     <= rcnt + 1;
        xr_ready <= !rdy_mode || (rcnt % 3 != 0);
    end

    // monitor: compare reads and requests against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            chk(!pend, "R2 read while another outstanding", {63'b0, pend}, 64'd0);
            if (exp_addr.size() == 0)
                chk(1'b0, "R2 unexpected read", {32'b0, mem_addr}, 64'd0);
            else begin
                logic [31:0] e;
                e = exp_addr.pop_front();
                chk(mem_addr == e, "R2 read address", {32'b0, mem_addr}, {32'b0, e});
            end
        end
        if (!rst && xr_valid && xr_ready) begin
            logic [58:0] a;
            a = {xr_func_addr, xr_ep_num, xr_low_speed, xr_max_pkt, xr_dir, xr_iso, xr_early_in, xr_td_addr};
            if (exp_xr.size() == 0)
                chk(1'b0, "R4/R5 unexpected request", {5'b0, a}, 64'd0);
            else begin
                logic [58:0] e;
                e = exp_xr.pop_front();
                chk(a == e, "R6/R7 request payload", {5'b0, a}, {5'b0, e});
            end
        end
    end

    task automatic put_ed(input int slot, input logic [6:0] fa, input logic [3:0] ep,
                          input logic [1:0] dir, input bit spd, input bit skip, input bit iso,
                          input logic [10:0] mps, input logic [31:0] tail, input logic [31:0] head,
                          input bit halt, input logic [31:0] nxt);
        mem[slot*4 + 0] = {5'b0, mps, iso, skip, spd, dir, ep, fa};
        mem[slot*4 + 1] = tail;
        mem[slot*4 + 2] = head | {31'b0, halt};
        mem[slot*4 + 3] = nxt;
    endtask

    // reference walk derived from the requirements
    task automatic predict(input logic [31:0] head, output bit e_rd, output bit e_al, output bit e_lp);
        logic [31:0] addr;
        logic [31:0] w [4];
        int visits;
        logic [1:0] d;
        addr = head & ~32'hF;
        visits = 0;
        e_rd = 0; e_al = 0; e_lp = 0;
        while (addr != 0) begin
            for (int k = 0; k < 4; k++) begin
                exp_addr.push_back(addr + 32'(4 * k));
                if (err_on && (addr + 32'(4 * k)) == err_addr) begin
                    e_rd = 1;
                    return;
                end
                w[k] = mem[(addr >> 2) + 32'(k)];
            end
            visits++;
            if (!(w[0][14] || w[2][0])) begin
                if (w[0][15] && (w[1][4] || w[2][4])) begin
                    e_al = 1;
                    return;
                end
                if (w[1][31:4] != w[2][31:4]) begin
                    d = (w[0][12:11] == 2'b01) ? 2'b01 : (w[0][12:11] == 2'b10) ? 2'b10 : 2'b00;
                    exp_xr.push_back({w[0][6:0], w[0][10:7], w[0][13], w[0][26:16], d, w[0][15],
                                      (w[0][12:11] == 2'b10), w[2][31:4], 4'b0});
                end
            end
            if ((w[3] & ~32'hF) == 0) break;
            if (visits == LIMIT) begin
                e_lp = 1;
                return;
            end
            addr = w[3] & ~32'hF;
        end
    endtask

    task automatic walk(input logic [31:0] head, input string tag, input bit poke, input logic [31:0] poke_head);
        bit e_rd, e_al, e_lp;
        int t;
        predict(head, e_rd, e_al, e_lp);
        @(negedge clk);
        list_head = head;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R12 busy before second start", {63'b0, busy}, 64'd1);
            list_head = poke_head;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            list_head = head;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, {tag, " R3 done pulse"}, {63'b0, done}, 64'd1);
        chk(err_read == e_rd, {tag, " R10 read error flag"}, {63'b0, err_read}, {63'b0, e_rd});
        chk(err_align == e_al, {tag, " R9 align error flag"}, {63'b0, err_align}, {63'b0, e_al});
        chk(err_loop == e_lp, {tag, " R11 loop error flag"}, {63'b0, err_loop}, {63'b0, e_lp});
        @(negedge clk);
        chk(busy == 1'b0, {tag, " R3 idle after walk"}, {63'b0, busy}, 64'd0);
        chk(exp_addr.size() == 0, {tag, " R2 reads missing"}, 64'(exp_addr.size()), 64'd0);
        chk(exp_xr.size() == 0, {tag, " R6 requests missing"}, 64'(exp_xr.size()), 64'd0);
        exp_addr.delete();
        exp_xr.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        rst = 1'b1;
        start = 1'b0;
        list_head = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, mem_req, xr_valid, err_read, err_align, err_loop} == 7'b0,
            "R1 reset outputs", {57'b0, busy, done, mem_req, xr_valid, err_read, err_align, err_loop}, 64'd0);

        // R3 zero head: done with no reads
        walk(32'h0000_000C, "zero head", 1'b0, '0);

        // main chain: OUT, IN, dir 00, dir 11, skip, empty, halted (R4 R5 R6 R7)
        put_ed(1, 7'h05, 4'h1, 2'b01, 0, 0, 0, 11'd64,  32'h0000_1000, 32'h0000_2000, 0, 32'h20);
        put_ed(2, 7'h7F, 4'hF, 2'b10, 1, 0, 0, 11'd8,   32'h0000_3000, 32'h0000_3040, 0, 32'h30);
        put_ed(3, 7'h12, 4'h3, 2'b00, 0, 0, 0, 11'd1023, 32'h0000_4000, 32'h0000_4100, 0, 32'h40);
        put_ed(4, 7'h40, 4'h8, 2'b11, 1, 0, 0, 11'd512, 32'h0000_5010, 32'h0000_5000, 0, 32'h55);
        put_ed(5, 7'h22, 4'h2, 2'b01, 0, 1, 0, 11'd32,  32'h0000_6000, 32'h0000_6100, 0, 32'h70);
        put_ed(7, 7'h23, 4'h2, 2'b10, 0, 0, 0, 11'd32,  32'h0000_6004, 32'h0000_600A, 0, 32'h60);
        put_ed(6, 7'h24, 4'h4, 2'b10, 0, 0, 0, 11'd16,  32'h0000_7000, 32'hABCD_0000, 1, 32'h0000_000C);
        lat_cfg = 0;
        rdy_mode = 1'b0;
        walk(32'h0000_0013, "chain fast R4 R5", 1'b0, '0);
        lat_cfg = 2;
        rdy_mode = 1'b1;
        walk(32'h0000_0010, "chain slow R8", 1'b0, '0);

        // isochronous: aligned request, skipped misaligned, then misaligned abort (R9)
        put_ed(8,  7'h31, 4'h5, 2'b10, 0, 0, 1, 11'd1023, 32'h0000_7000, 32'h0000_7020, 0, 32'h90);
        put_ed(9,  7'h32, 4'h6, 2'b01, 0, 1, 1, 11'd100,  32'h0000_7000, 32'h0000_7010, 0, 32'hA0);
        put_ed(10, 7'h33, 4'h7, 2'b01, 0, 0, 1, 11'd100,  32'h0000_8000, 32'h0000_8010, 0, 32'hB0);
        put_ed(11, 7'h34, 4'h7, 2'b01, 0, 0, 0, 11'd100,  32'h0000_9000, 32'h0000_9100, 0, 32'h0);
        walk(32'h0000_0080, "iso R9", 1'b0, '0);

        // read error on word 2 of the second descriptor (R10)
        lat_cfg = 1;
        err_on = 1'b1;
        err_addr = 32'h0000_0028;
        walk(32'h0000_0010, "read err R10", 1'b0, '0);
        err_on = 1'b0;

        // self-linked descriptor hits the visit limit (R11)
        put_ed(12, 7'h0A, 4'h9, 2'b01, 0, 0, 0, 11'd64, 32'h0000_A000, 32'h0000_A100, 0, 32'hC0);
        walk(32'h0000_00C0, "loop R11", 1'b0, '0);

        // start while busy ignored; flags cleared by accepted start (R12)
        lat_cfg = 0;
        rdy_mode = 1'b0;
        walk(32'h0000_0010, "poke R12", 1'b1, 32'h0000_00C0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule